// File: doc/BRIEF.md
# Dual-Edge Carry-Save Timebase

This block is a free-running time counter that advances once on every rising edge and once on every falling edge of a fast clock. One count is therefore half a fast-clock period. In the intended system the fast clock is five times a reference clock, at 250 MHz, so the count resolution is 2 ns. Other blocks take timestamps by sampling the count.

The count is held in redundant carry-save form, as a sum word and a carry word, each `W` bits wide (64 by default). The count they represent is `sum + 2*carry` modulo 2^W. Each tick updates every bit position only from itself and its lower neighbour, so no carry chain runs across the word. Two register banks produce the dual-edge behaviour. One bank is clocked on the rising edge and the other on the falling edge. The live state is the bitwise XOR of the two banks, so no clock-level multiplexer, gated clock or derived clock is needed.

A binary value resolved from the two words is also output, for checking only. Two configurable low-order bits of the count are brought out as slow toggling taps, for observing the count rate on a scope. A synchronous reset, sampled at each edge of either polarity, forces the count to zero at that edge. The block has no streaming data path, so it has no valid/ready interface, and all of its pins are plain control and status.

Top module: `dual_edge_timebase`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, `ts_sum` and `ts_carry` are both all-zero after that edge.
- R2: When `rst` is low at an edge of either polarity, `ts_value` after that edge equals its value before the edge plus one, modulo 2^W.
- R3: After every edge, `ts_sum + 2*ts_carry` modulo 2^W equals the count.
- R4: On each non-reset edge, bit i updates as `sum_i' = sum_i XOR c_i` and `carry_i' = sum_i AND c_i`. Here c_0 = 1 and c_i (i > 0) is carry_(i-1) from before the edge.
- R5: No bit position ever has its sum bit and its carry bit set at the same time.
- R6: `obs_tap[0]` equals bit TAP_A (default 4) of the count, and `obs_tap[1]` equals bit TAP_B (default 8) of the count.
- R7: The count wraps from 2^W-1 to 0 on the next non-reset edge.
- R8: When `rst` is high at a falling edge of `clk`, `ts_sum` and `ts_carry` are both all-zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; both edges advance the count |
| rst | input | 1 | Synchronous reset, sampled at both edges |
| ts_sum | output | W | Sum word of the carry-save count |
| ts_carry | output | W | Carry word of the carry-save count (weight 2) |
| ts_value | output | W | Resolved binary count, for checking |
| obs_tap | output | 2 | Count bits TAP_A and TAP_B for observation |

## Verification
The bench builds two instances side by side on one clock and reset. One keeps the default W = 64, with taps at bits 4 and 8, so the full-width sum and carry words are compared against the bit-update rule. The other uses W = 10. Its count passes 2^10 within about a thousand edges, which brings the wrap from all ones to zero within reach of a short run. The reset is applied once at a lone rising edge and once at a lone falling edge, which shows that each bank honours it.

// File: rtl/det_pkg.sv
package det_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } det_edge_e;

  localparam int unsigned DET_W_DEFAULT = 64;
endpackage

// File: rtl/det_cs_step.sv
module det_cs_step #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] cur_sum,
  input  logic [W-1:0] cur_carry,
  output logic [W-1:0] nxt_sum,
  output logic [W-1:0] nxt_carry
);
  // incoming carry per position: constant one at the bottom, lower carry above
  logic [W-1:0] cin;
  assign cin = {cur_carry[W-2:0], 1'b1};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt_sum[i]   = cur_sum[i] ^ cin[i];
    assign nxt_carry[i] = cur_sum[i] & cin[i];
  end
endmodule

// File: rtl/det_edge_bank.sv
module det_edge_bank
  import det_pkg::*;
#(
  parameter int unsigned W    = 64,
  parameter det_edge_e   EDGE = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_sum,
  input  logic [W-1:0] nxt_carry,
  input  logic [W-1:0] oth_sum,
  input  logic [W-1:0] oth_carry,
  output logic [W-1:0] q_sum,
  output logic [W-1:0] q_carry
);
  // Stored so that (this bank XOR partner) equals the wanted state.
  // Reset copies the partner, giving a zero combined state.
  logic [W-1:0] d_sum, d_carry;
  assign d_sum   = rst ? oth_sum   : (nxt_sum   ^ oth_sum);
  assign d_carry = rst ? oth_carry : (nxt_carry ^ oth_carry);

  if (EDGE == EDGE_RISE) begin : g_rise
    always_ff @(posedge clk) begin
      q_sum   <= d_sum;
      q_carry <= d_carry;
    end
  end else begin : g_fall
    always_ff @(negedge clk) begin
      q_sum   <= d_sum;
      q_carry <= d_carry;
    end
  end
endmodule

// File: rtl/det_resolve.sv
module det_resolve #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] cs_sum,
  input  logic [W-1:0] cs_carry,
  output logic [W-1:0] bin_value
);
  logic [W-1:0] carry_weighted;
  assign carry_weighted = {cs_carry[W-2:0], 1'b0};
  assign bin_value      = cs_sum + carry_weighted;
endmodule

// File: rtl/dual_edge_timebase.sv
module dual_edge_timebase
  import det_pkg::*;
#(
  parameter int unsigned W     = DET_W_DEFAULT,
  parameter int unsigned TAP_A = 4,
  parameter int unsigned TAP_B = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] ts_sum,
  output logic [W-1:0] ts_carry,
  output logic [W-1:0] ts_value,
  output logic [1:0]   obs_tap
);
  localparam int unsigned NBANK = 2;

  logic [W-1:0] bank_sum   [NBANK];
  logic [W-1:0] bank_carry [NBANK];
  logic [W-1:0] step_sum, step_carry;

  // live state: XOR of both edge banks
  assign ts_sum   = bank_sum[0]   ^ bank_sum[1];
  assign ts_carry = bank_carry[0] ^ bank_carry[1];

  det_cs_step #(.W(W)) u_step (
    .cur_sum  (ts_sum),
    .cur_carry(ts_carry),
    .nxt_sum  (step_sum),
    .nxt_carry(step_carry)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam det_edge_e BEDGE = (b == 0) ? EDGE_RISE : EDGE_FALL;
    det_edge_bank #(.W(W), .EDGE(BEDGE)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .nxt_sum  (step_sum),
      .nxt_carry(step_carry),
      .oth_sum  (bank_sum[NBANK-1-b]),
      .oth_carry(bank_carry[NBANK-1-b]),
      .q_sum    (bank_sum[b]),
      .q_carry  (bank_carry[b])
    );
  end

  det_resolve #(.W(W)) u_resolve (
    .cs_sum   (ts_sum),
    .cs_carry (ts_carry),
    .bin_value(ts_value)
  );

  assign obs_tap = {ts_value[TAP_B], ts_value[TAP_A]};
endmodule

// File: rtl/dual_edge_timebase_chk.sv
module dual_edge_timebase_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ts_sum,
  input logic [W-1:0] ts_carry,
  input logic [W-1:0] ts_value
);
  logic         pos_seen = 1'b0, neg_seen = 1'b0;
  logic         pos_vld  = 1'b0, neg_vld  = 1'b0;
  logic         pos_rst  = 1'b0, neg_rst  = 1'b0;
  logic [W-1:0] pos_snap = '0,   neg_snap = '0;

  always_ff @(posedge clk) begin
    pos_seen <= pos_seen | rst;
    pos_vld  <= pos_seen | neg_seen;
    pos_rst  <= rst;
    pos_snap <= ts_value;
  end

  always_ff @(negedge clk) begin
    neg_seen <= neg_seen | rst;
    neg_vld  <= pos_seen | neg_seen;
    neg_rst  <= rst;
    neg_snap <= ts_value;
  end

  // R2
  adv_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (neg_vld && !neg_rst) |-> (ts_value == neg_snap + W'(1)));

  // R2
  adv_rise_chk: assert property (@(negedge clk) disable iff (rst)
    (pos_vld && !pos_rst) |-> (ts_value == pos_snap + W'(1)));

  // R1
  rise_reset_chk: assert property (@(negedge clk) disable iff (rst)
    pos_rst |-> (ts_sum == '0 && ts_carry == '0));

  // R8
  fall_reset_chk: assert property (@(posedge clk) disable iff (rst)
    neg_rst |-> (ts_sum == '0 && ts_carry == '0));

  // R5
  disjoint_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (pos_seen || neg_seen) |-> ((ts_sum & ts_carry) == '0));

  // R5
  disjoint_fall_chk: assert property (@(negedge clk) disable iff (rst)
    (pos_seen || neg_seen) |-> ((ts_sum & ts_carry) == '0));
endmodule

bind dual_edge_timebase dual_edge_timebase_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ts_sum  (ts_sum),
  .ts_carry(ts_carry),
  .ts_value(ts_value)
);

// File: tb/dual_edge_timebase_bench.sv
module dual_edge_timebase_bench;
  localparam int CLK_PERIOD = 8;
  localparam int NW = 10;

  typedef struct {
    logic [63:0] cnt;
    logic [63:0] sum;
    logic [63:0] carry;
    logic        rst_edge;
    logic        rising;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] w_sum, w_carry, w_value;
  logic [1:0]  w_tap;
  logic [NW-1:0] n_sum, n_carry, n_value;
  logic [1:0]  n_tap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_edge_timebase u_dual_edge_timebase (
    .clk(clk), .rst(rst), .ts_sum(w_sum), .ts_carry(w_carry),
    .ts_value(w_value), .obs_tap(w_tap)
  );

  dual_edge_timebase #(.W(NW)) u_dual_edge_timebase_narrow (
    .clk(clk), .rst(rst), .ts_sum(n_sum), .ts_carry(n_carry),
    .ts_value(n_value), .obs_tap(n_tap)
  );

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [63:0] m_cnt = '0, m_sum = '0, m_carry = '0;
  logic m_rise = 1'b1;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one expected item per edge, set up between edges
  task automatic drive(input int n, input logic r);
    for (int k = 0; k < n; k++) begin
      logic [63:0] cin;
      item_t it;
      rst = r;
      if (r) begin
        m_cnt = '0; m_sum = '0; m_carry = '0;
      end else begin
        cin     = {m_carry[62:0], 1'b1};   // R4 rule
        m_carry = m_sum & cin;
        m_sum   = m_sum ^ cin;
        m_cnt   = m_cnt + 64'd1;
      end
      it.cnt = m_cnt; it.sum = m_sum; it.carry = m_carry;
      it.rst_edge = r; it.rising = m_rise;
      q.push_back(it);
      m_rise = ~m_rise;
      @(clk);
      #(CLK_PERIOD/8);
    end
  endtask

  // monitor: sample a quarter period after each edge
  initial begin
    forever begin
      @(clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        item_t e;
        logic [63:0] res;
        e = q.pop_front();
        res = w_sum + {w_carry[62:0], 1'b0};
        chk(w_value == e.cnt, "R2 wide count", w_value, e.cnt);
        chk(n_value == e.cnt[NW-1:0], "R2 narrow count", 64'(n_value), 64'(e.cnt[NW-1:0]));
        chk(res == e.cnt, "R3 sum+2carry", res, e.cnt);
        chk(w_sum == e.sum, "R4 sum word", w_sum, e.sum);
        chk(w_carry == e.carry, "R4 carry word", w_carry, e.carry);
        chk(n_sum == e.sum[NW-1:0], "R4 narrow sum", 64'(n_sum), 64'(e.sum[NW-1:0]));
        chk((w_sum & w_carry) == '0, "R5 disjoint", w_sum & w_carry, 64'd0);
        chk(w_tap == {e.cnt[8], e.cnt[4]}, "R6 wide taps", 64'(w_tap), 64'({e.cnt[8], e.cnt[4]}));
        chk(n_tap == {e.cnt[8], e.cnt[4]}, "R6 narrow taps", 64'(n_tap), 64'({e.cnt[8], e.cnt[4]}));
        if (!e.rst_edge && e.cnt[NW-1:0] == '0)
          chk(n_value == '0 && w_value[NW] == 1'b1 || w_value == e.cnt && n_value == '0,
              "R7 narrow wrap", 64'(n_value), 64'd0);
        if (e.rst_edge && e.rising)
          chk(w_sum == '0 && w_carry == '0, "R1 rising reset", w_sum | w_carry, 64'd0);
        if (e.rst_edge && !e.rising)
          chk(w_sum == '0 && w_carry == '0 && n_sum == '0 && n_carry == '0,
              "R8 falling reset", w_sum | w_carry, 64'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD/8);
    drive(3, 1'b1);      // reset across rising and falling edges
    drive(40, 1'b0);
    drive(1, 1'b1);      // edge 44: a lone falling edge
    drive(1100, 1'b0);   // narrow copy passes 2^10
    drive(1, 1'b1);      // edge 1145: a lone rising edge
    drive(25, 1'b0);
    #(CLK_PERIOD);
    chk(q.size() == 0, "R2 queue drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired act=%0d exp=0 pending", q.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule